// File: doc/BRIEF.md
# Dual Configurable Decade Counter

Two independent four-bit decade counters that run entirely on one system clock. Each decade is built from a one-bit divide-by-2 stage and a three-bit divide-by-5 stage, and each stage has its own external count input. The count inputs are asynchronous levels. Each one is synchronised, and its high-to-low transition becomes a single-cycle count enable, so no stage is clocked by another stage's output.

A static mode bit per decade chains the two stages. In BCD order, a falling divide-by-2 output advances the divide-by-5 stage. In bi-quinary order, a falling divide-by-5 top bit advances the divide-by-2 stage. A cascade input feeds the carry of decade 0 into the first stage of decade 1, so the block can divide an input rate by 100. Each decade has an active-high clear. The shared active-low reset clears everything.

Top module: `dual_decade_counter`

## Requirements
- R1: In BCD mode the divide-by-2 bit (nibble bit 0) toggles once for each high-to-low transition of that decade's cp0_i. A low-to-high transition changes nothing.
- R2: The divide-by-5 stage sits in nibble bits 3:1 as a binary value. It steps 0,1,2,3,4 and then wraps to 0. Bit 3 is high only in state 4.
- R3: In BCD mode (mode_i[d]=0) the nibble counts 0 to 9 in binary and wraps to 0 on the tenth edge of cp0_i. The external cp1_i of that decade is ignored.
- R4: In bi-quinary mode (mode_i[d]=1) cp1_i drives the divide-by-5 stage, and its wrap from 4 to 0 toggles bit 0. The external cp0_i is ignored. For a count n from 0 to 9, bits 3:1 equal n mod 5 and bit 0 equals (n>=5), so bit 0 is high for 5 of every 10 counts.
- R5: clr_i[d] high forces nibble d to zero at once, without waiting for a clock. The other nibble keeps its value.
- R6: After clr_i[d] or rst_ni is released, a count input held high through the clear produces no count. Counting resumes on that input's next real falling transition.
- R7: The nibble changes at the third rising clk_i edge after a count input falls, counting the first edge that samples the low level.
- R8: With cascade_i=1, decade 1's first stage (cp0 side in BCD, cp1 side in bi-quinary) is advanced by decade 0's most significant output falling: bit 3 in BCD, bit 0 in bi-quinary. That external input of decade 1 is then ignored. The pair divides by 100.
- R9: rst_ni low clears both nibbles asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 2 | Per-decade clear, active high |
| mode_i | input | 2 | Per-decade chaining: 0 BCD, 1 bi-quinary |
| cascade_i | input | 1 | Feed decade 0 carry into decade 1 |
| cp0_i | input | 2 | Divide-by-2 count input per decade |
| cp1_i | input | 2 | Divide-by-5 count input per decade |
| q_o | output | 8 | Decade d in bits 4d+3:4d; bit 4d is the divide-by-2 output |

## Verification
The assertions assume three things about the inputs. Each count input stays at a level for at least two system clocks. mode_i and cascade_i change only while the affected decade is held in clear. A clear lasts at least one clock. The bench keeps every count pulse four clocks high and four clocks low, and it applies mode and cascade settings only inside a clear window. Under those conditions the edge detector's single-cycle pulse and the range checks on each nibble stay valid.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic {
    CHAIN_BCD = 1'b0,
    CHAIN_BIQ = 1'b1
  } chain_e;

  localparam int unsigned DIV5_W    = 3;
  localparam logic [DIV5_W-1:0] DIV5_LAST = 3'd4;
endpackage

// File: rtl/dcnt_clr_sync.sv
module dcnt_clr_sync #(
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic arst_no,
  output logic hold_o
);
  logic [HOLD_CYCLES-1:0] hold_q;

  // assertion is asynchronous, release is stretched over HOLD_CYCLES edges
  assign arst_no = rst_ni & ~clr_i;

  always_ff @(posedge clk_i or negedge arst_no) begin
    if (!arst_no) hold_q <= '1;
    else          hold_q <= hold_q << 1;
  end

  assign hold_o = hold_q[HOLD_CYCLES-1];
endmodule

// File: rtl/dcnt_fall_det.sv
module dcnt_fall_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic hold_i,
  input  logic cnt_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else if (hold_i) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= SYNC_STAGES'({sync_q, cnt_i});
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

  AST_FALL_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!arst_ni)
    fall_o |-> !$past(cnt_i)); // R7
endmodule

// File: rtl/dcnt_decade.sv
module dcnt_decade
  import dcnt_pkg::*;
(
  input  logic       clk_i,
  input  logic       arst_ni,
  input  logic       hold_i,
  input  chain_e     mode_i,
  input  logic       fall0_i,
  input  logic       fall1_i,
  output logic [3:0] q_o,
  output logic       carry_o
);
  logic              q0_q;
  logic [DIV5_W-1:0] s5_q;
  logic              adv2, adv5, s5_last;

  assign s5_last = (s5_q == DIV5_LAST);

  // chained stage advances in the same cycle as the edge of its driver
  always_comb begin
    if (mode_i == CHAIN_BCD) begin
      adv2 = fall0_i;
      adv5 = fall0_i & q0_q;
    end else begin
      adv5 = fall1_i;
      adv2 = fall1_i & s5_last;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      q0_q <= 1'b0;
      s5_q <= '0;
    end else if (hold_i) begin
      q0_q <= 1'b0;
      s5_q <= '0;
    end else begin
      if (adv2) q0_q <= ~q0_q;
      if (adv5) s5_q <= s5_last ? '0 : s5_q + 1'b1;
    end
  end

  assign q_o     = {s5_q, q0_q};
  assign carry_o = (mode_i == CHAIN_BCD) ? (adv5 & s5_last) : (adv2 & q0_q);

  AST_DIV2_TOGGLE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (mode_i == CHAIN_BCD && fall0_i && !hold_i) |=> (q_o[0] != $past(q_o[0]))); // R1
  AST_DIV5_RANGE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    q_o[3:1] <= 3'd4); // R2
  AST_BCD_RANGE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (mode_i == CHAIN_BCD) |-> (q_o <= 4'd9)); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (!fall0_i && !fall1_i && !hold_i) |=> $stable(q_o)); // R1
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!arst_ni)
    hold_i |-> (q_o == 4'd0)); // R6
  AST_CARRY_MSB_LOW: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (carry_o && !hold_i) |=> ((mode_i == CHAIN_BCD) ? !q_o[3] : !q_o[0])); // R8
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import dcnt_pkg::*;
#(
  parameter int unsigned N_DEC       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_DEC-1:0]   clr_i,
  input  logic [N_DEC-1:0]   mode_i,
  input  logic               cascade_i,
  input  logic [N_DEC-1:0]   cp0_i,
  input  logic [N_DEC-1:0]   cp1_i,
  output logic [4*N_DEC-1:0] q_o
);
  localparam int unsigned Q_W = 4;

  logic [N_DEC-1:0] arst_n, hold, ext_f0, ext_f1, f0, f1, carry;

  for (genvar d = 0; d < N_DEC; d++) begin : g_dec
    chain_e mode_d;
    assign mode_d = chain_e'(mode_i[d]);

    dcnt_clr_sync #(.HOLD_CYCLES(HOLD_CYCLES)) u_clr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i[d]),
      .arst_no(arst_n[d]),
      .hold_o (hold[d])
    );

    dcnt_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fd0 (
      .clk_i  (clk_i),
      .arst_ni(arst_n[d]),
      .hold_i (hold[d]),
      .cnt_i  (cp0_i[d]),
      .fall_o (ext_f0[d])
    );

    dcnt_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fd1 (
      .clk_i  (clk_i),
      .arst_ni(arst_n[d]),
      .hold_i (hold[d]),
      .cnt_i  (cp1_i[d]),
      .fall_o (ext_f1[d])
    );

    if (d == 0) begin : g_head
      assign f0[d] = ext_f0[d];
      assign f1[d] = ext_f1[d];
    end else begin : g_chain
      // carry enters whichever stage comes first in this decade's order
      assign f0[d] = cascade_i ? (carry[d-1] & (mode_d == CHAIN_BCD)) : ext_f0[d];
      assign f1[d] = cascade_i ? (carry[d-1] & (mode_d == CHAIN_BIQ)) : ext_f1[d];
    end

    dcnt_decade u_dec (
      .clk_i  (clk_i),
      .arst_ni(arst_n[d]),
      .hold_i (hold[d]),
      .mode_i (mode_d),
      .fall0_i(f0[d]),
      .fall1_i(f1[d]),
      .q_o    (q_o[Q_W*d +: Q_W]),
      .carry_o(carry[d])
    );

    AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[d] |-> (q_o[Q_W*d +: Q_W] == '0)); // R5
  end

  AST_RST_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0)); // R9
endmodule

// File: tb/tb_dual_decade_counter.sv
module tb_dual_decade_counter;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NV = 15;

  typedef struct packed {
    logic [1:0] clr;
    logic [1:0] mode;
    logic       casc;
    logic [1:0] sel;   // 0 cp0[0], 1 cp1[0], 2 cp0[1], 3 cp1[1]
    logic [7:0] n;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'b11, 2'b00, 1'b0, 2'd0, 8'd7,  8'h07}, // R1 R3 count 7
    '{2'b00, 2'b00, 1'b0, 2'd0, 8'd3,  8'h00}, // R3 wrap at ten
    '{2'b00, 2'b00, 1'b0, 2'd1, 8'd4,  8'h00}, // R3 cp1 ignored in BCD
    '{2'b00, 2'b00, 1'b0, 2'd0, 8'd9,  8'h09}, // R3 nine
    '{2'b00, 2'b00, 1'b0, 2'd2, 8'd5,  8'h59}, // R3 decade 1
    '{2'b01, 2'b01, 1'b0, 2'd1, 8'd3,  8'h56}, // R2 R5 biq 3, d1 kept
    '{2'b00, 2'b01, 1'b0, 2'd1, 8'd2,  8'h51}, // R4 biq 5
    '{2'b00, 2'b01, 1'b0, 2'd0, 8'd3,  8'h51}, // R4 cp0 ignored in biq
    '{2'b00, 2'b01, 1'b0, 2'd1, 8'd4,  8'h59}, // R2 R4 biq 9
    '{2'b00, 2'b01, 1'b0, 2'd1, 8'd1,  8'h50}, // R4 wrap
    '{2'b11, 2'b00, 1'b1, 2'd0, 8'd25, 8'h25}, // R8 BCD cascade
    '{2'b00, 2'b00, 1'b1, 2'd2, 8'd3,  8'h25}, // R8 external d1 ignored
    '{2'b00, 2'b00, 1'b1, 2'd0, 8'd75, 8'h00}, // R8 divide by 100
    '{2'b11, 2'b01, 1'b1, 2'd1, 8'd23, 8'h26}, // R8 biq d0 into BCD d1
    '{2'b11, 2'b11, 1'b1, 2'd1, 8'd57, 8'h15}  // R8 both biq
  };

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [1:0] clr_i, mode_i, cp0_i, cp1_i;
  logic       cascade_i;
  logic [7:0] q_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_decade_counter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .mode_i(mode_i),
    .cascade_i(cascade_i), .cp0_i(cp0_i), .cp1_i(cp1_i), .q_o(q_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_in(input logic [1:0] sel, input logic v);
    case (sel)
      2'd0: cp0_i[0] = v;
      2'd1: cp1_i[0] = v;
      2'd2: cp0_i[1] = v;
      default: cp1_i[1] = v;
    endcase
  endtask

  task automatic pulse(input logic [1:0] sel);
    @(negedge clk_i) set_in(sel, 1'b1);
    repeat (4) @(negedge clk_i);
    set_in(sel, 1'b0);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic clear(input logic [1:0] m, input logic [1:0] md, input logic cs);
    @(negedge clk_i) clr_i = m;
    #1;
    for (int d = 0; d < 2; d++)
      if (m[d]) check("R5 async clear", {4'h0, q_o[4*d +: 4]}, 8'h00);
    mode_i = md;
    cascade_i = cs;
    repeat (2) @(negedge clk_i);
    clr_i = 2'b00;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi;
    rst_ni = 1'b0; clr_i = 2'b00; mode_i = 2'b00; cascade_i = 1'b0;
    cp0_i = 2'b00; cp1_i = 2'b00;
    repeat (3) @(negedge clk_i);
    check("R9 reset state", q_o, 8'h00);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].clr != 2'b00) clear(VEC[i].clr, VEC[i].mode, VEC[i].casc);
      for (int k = 0; k < VEC[i].n; k++) pulse(VEC[i].sel);
      $display("vector %0d", i);
      check("R1-R8 vector table", q_o, VEC[i].exp);
    end

    // R7: latency from falling input to output
    clear(2'b11, 2'b00, 1'b0);
    @(negedge clk_i) cp0_i[0] = 1'b1;
    repeat (4) @(negedge clk_i);
    cp0_i[0] = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R7 no change after two edges", q_o, 8'h00);
    @(negedge clk_i);
    check("R7 change on third edge", q_o, 8'h01);

    // R6: input held high through clear gives no count
    @(negedge clk_i) cp0_i[0] = 1'b1;
    repeat (4) @(negedge clk_i);
    clear(2'b01, 2'b00, 1'b0);
    repeat (6) @(negedge clk_i);
    check("R6 no spurious count", q_o, 8'h00);
    cp0_i[0] = 1'b0;
    repeat (4) @(negedge clk_i);
    check("R6 counting resumes", q_o, 8'h01);

    // R4: divide-by-2 output duty in bi-quinary
    clear(2'b01, 2'b01, 1'b0);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      pulse(2'd1);
      if (q_o[0]) hi++;
    end
    check("R4 duty high count", 8'(hi), 8'd5);
    check("R4 back to zero", q_o, 8'h00);

    // R9: asynchronous reset mid-run
    for (int k = 0; k < 3; k++) pulse(2'd1);
    pulse(2'd2);
    check("R9 prior value", q_o, 8'h16);
    @(negedge clk_i) rst_ni = 1'b0;
    #1;
    check("R9 async reset", q_o, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule